// File: doc/BRIEF.md
# Machine Cycle State Sequencer

This block is the timing generator of an 8051-style processor core. It splits the oscillator clock into machine cycles. Each machine cycle has six states, and each state has a first and a second phase of one oscillator period each. So one machine cycle lasts twelve clock periods. For every machine cycle of an instruction, the sequencer tells the rest of the core which state and phase is current. It also raises the program-fetch strobe, the opcode-latch strobe, the program-counter increment enable, the external-data-cycle flag and a one-clock end-of-instruction pulse.

The core's decoder presents an instruction class together with a start request. The sequencer waits at state 1, phase 1 of an instruction boundary until a start arrives. It samples the class in that period and then runs the instruction for one or two machine cycles. Every machine cycle fetches twice, in state 1 and in state 4. A fetch the instruction does not need is still issued, but it does not advance the program counter. The second cycle of an external data move is the only cycle with no fetch at all. If a start is waiting when one instruction ends, the next instruction begins on the following clock.

Top module: `mc_state_seq`

## Requirements
- R1: While reset is asserted, and afterwards while no instruction is running and `insn_start` is low, `state_num` is 1 and `phase_p2` is 0. In those periods `fetch_stb`, `opcode_latch`, `pc_inc_en`, `xdata_cycle` and `insn_end` are all 0.
- R2: While an instruction runs, every state lasts two clock periods: phase 1 (`phase_p2`=0) and then phase 2 (`phase_p2`=1). The states run 1,2,3,4,5,6 in that order, so a machine cycle lasts 12 clock periods.
- R3: If `insn_start` is high at an instruction boundary (state 1, phase 1), `opcode_latch` is high for exactly that period. The class on `insn_class` is captured in that period. Any later change on `insn_class` during the instruction has no effect.
- R4: `fetch_stb` is high in state 1 phase 1 and in state 4 phase 1 of every machine cycle, except as stated in R6. It is low in all other periods.
- R5: `pc_inc_en` is high with the opcode fetch. It is also high at the state 4 fetch of the first machine cycle when the class is two-byte (1 = two-byte one-cycle, 3 = two-byte two-cycle). It is low for every other fetch.
- R6: Class 4 (external data move) takes two machine cycles. During the whole second cycle (12 periods) `xdata_cycle` is high and `fetch_stb` and `pc_inc_en` stay low.
- R7: `insn_end` is high for one period: state 6, phase 2 of the final machine cycle. The final cycle is the first cycle for class 0 (one-byte one-cycle) and class 1. It is the second cycle for classes 2 (one-byte two-cycle), 3 and 4. Classes 5 to 7 behave as class 0.
- R8: When `insn_start` is high in the period after `insn_end`, the next instruction's opcode latch happens in that period, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_start | input | 1 | Start request for the next instruction, honoured at an instruction boundary |
| insn_class | input | 3 | Instruction class, sampled with the opcode latch |
| state_num | output | 3 | Current state, 1 to 6 |
| phase_p2 | output | 1 | 0 = phase 1, 1 = phase 2 |
| fetch_stb | output | 1 | Program fetch strobe |
| opcode_latch | output | 1 | Latch the fetched byte into the instruction register |
| pc_inc_en | output | 1 | Advance the program counter on this fetch |
| xdata_cycle | output | 1 | Second machine cycle of an external data move |
| insn_end | output | 1 | Last period of the instruction |

## Verification
The bench builds the block with its default parameters: six states per machine cycle, the second fetch in state 4, and at most two machine cycles per instruction. With these values every instruction ends within 24 clock periods. The bench can therefore compare every period of every class against a schedule it derives from the period count alone. Running the classes back to back, with idle gaps and with a class that changes after the opcode latch, covers the boundary hand-off and the capture of the class.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_1B1C  = 3'd0,
    CLS_2B1C  = 3'd1,
    CLS_1B2C  = 3'd2,
    CLS_2B2C  = 3'd3,
    CLS_XMOVE = 3'd4
  } insn_cls_e;

  // class occupies a second code byte fetched in state 4 of cycle 0
  function automatic logic cls_two_byte(input logic [CLS_W-1:0] c);
    return (c == CLS_2B1C) || (c == CLS_2B2C);
  endfunction

  function automatic logic cls_xmove(input logic [CLS_W-1:0] c);
    return c == CLS_XMOVE;
  endfunction

  // number of machine cycles; unknown codes run as one cycle
  function automatic int unsigned cls_cycles(input logic [CLS_W-1:0] c);
    return ((c == CLS_1B2C) || (c == CLS_2B2C) || (c == CLS_XMOVE)) ? 2 : 1;
  endfunction
endpackage

// File: rtl/mcs_state_ctr.sv
`timescale 1ns/1ps
module mcs_state_ctr #(
  parameter int N_STATES = 6,
  localparam int IDX_W = $clog2(N_STATES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [IDX_W-1:0] st_idx,
  output logic             ph,
  output logic             wrap
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_STATES - 1);

  // final period of the machine cycle
  assign wrap = run && ph && (st_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_idx <= '0;
      ph     <= 1'b0;
    end else if (run) begin
      if (ph) begin
        ph     <= 1'b0;
        st_idx <= (st_idx == LAST) ? '0 : st_idx + 1'b1;
      end else begin
        ph <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcs_cycle_ctl.sv
`timescale 1ns/1ps
module mcs_cycle_ctl
  import mcs_pkg::*;
#(
  parameter int MAX_CYC = 2,
  localparam int CYC_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CLS_W-1:0] cls_in,
  input  logic             wrap,
  output logic             busy,
  output logic [CLS_W-1:0] cur_cls,
  output logic [CYC_W-1:0] cur_cyc,
  output logic             last_cyc
);
  logic [CLS_W-1:0] cls_q;
  logic [CYC_W-1:0] cyc_q;
  int unsigned      need;

  // before capture, the live input is the class of the starting instruction
  assign cur_cls  = busy ? cls_q : cls_in;
  assign cur_cyc  = busy ? cyc_q : '0;
  assign need     = cls_cycles(cur_cls);
  assign last_cyc = (cur_cyc == CYC_W'(need - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cls_q <= '0;
      cyc_q <= '0;
    end else if (!busy && start) begin
      busy  <= 1'b1;
      cls_q <= cls_in;
      cyc_q <= '0;
    end else if (busy && wrap) begin
      if (last_cyc) begin
        busy  <= 1'b0;
        cyc_q <= '0;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcs_strobe_dec.sv
`timescale 1ns/1ps
module mcs_strobe_dec
  import mcs_pkg::*;
#(
  parameter int N_STATES     = 6,
  parameter int FETCH2_STATE = 4,
  parameter int CYC_W        = 1,
  localparam int IDX_W = $clog2(N_STATES)
) (
  input  logic             active,
  input  logic             first,
  input  logic [IDX_W-1:0] st_idx,
  input  logic             ph,
  input  logic [CLS_W-1:0] cur_cls,
  input  logic [CYC_W-1:0] cur_cyc,
  input  logic             last_cyc,
  output logic             slot_a,
  output logic             slot_b,
  output logic             fetch_stb,
  output logic             opcode_latch,
  output logic             pc_inc_en,
  output logic             xdata_cycle,
  output logic             insn_end
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_STATES - 1);
  localparam logic [IDX_W-1:0] F2   = IDX_W'(FETCH2_STATE - 1);

  assign slot_a       = active && (st_idx == '0) && !ph;
  assign slot_b       = active && (st_idx == F2) && !ph;
  assign xdata_cycle  = active && cls_xmove(cur_cls) && (cur_cyc != '0);
  assign fetch_stb    = (slot_a || slot_b) && !xdata_cycle;
  assign opcode_latch = first;
  assign pc_inc_en    = first || (slot_b && (cur_cyc == '0) && cls_two_byte(cur_cls));
  assign insn_end     = active && ph && (st_idx == LAST) && last_cyc;
endmodule

// File: rtl/mc_state_seq.sv
`timescale 1ns/1ps
module mc_state_seq
  import mcs_pkg::*;
#(
  parameter int N_STATES     = 6,
  parameter int FETCH2_STATE = 4,
  parameter int MAX_CYC      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_start,
  input  logic [CLS_W-1:0] insn_class,
  output logic [2:0]       state_num,
  output logic             phase_p2,
  output logic             fetch_stb,
  output logic             opcode_latch,
  output logic             pc_inc_en,
  output logic             xdata_cycle,
  output logic             insn_end
);
  localparam int IDX_W = $clog2(N_STATES);
  localparam int CYC_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             busy;
  logic             run;
  logic             first;
  logic             wrap;
  logic             last_cyc;
  logic             slot_a;
  logic             slot_b;
  logic [IDX_W-1:0] st_idx;
  logic [CLS_W-1:0] cur_cls;
  logic [CYC_W-1:0] cur_cyc;

  assign run       = busy || insn_start;
  assign first     = !busy && insn_start;
  assign state_num = 3'(st_idx) + 3'd1;

  mcs_state_ctr #(.N_STATES(N_STATES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run),
    .st_idx(st_idx), .ph(phase_p2), .wrap(wrap)
  );

  mcs_cycle_ctl #(.MAX_CYC(MAX_CYC)) u_cyc (
    .clk(clk), .rst_n(rst_n), .start(insn_start), .cls_in(insn_class),
    .wrap(wrap), .busy(busy), .cur_cls(cur_cls), .cur_cyc(cur_cyc),
    .last_cyc(last_cyc)
  );

  mcs_strobe_dec #(.N_STATES(N_STATES), .FETCH2_STATE(FETCH2_STATE),
                   .CYC_W(CYC_W)) u_dec (
    .active(run), .first(first), .st_idx(st_idx), .ph(phase_p2),
    .cur_cls(cur_cls), .cur_cyc(cur_cyc), .last_cyc(last_cyc),
    .slot_a(slot_a), .slot_b(slot_b), .fetch_stb(fetch_stb),
    .opcode_latch(opcode_latch), .pc_inc_en(pc_inc_en),
    .xdata_cycle(xdata_cycle), .insn_end(insn_end)
  );
endmodule

// File: rtl/mc_state_seq_chk.sv
`timescale 1ns/1ps
module mc_state_seq_chk #(
  parameter int N_STATES = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       busy,
  input logic [2:0] state_num,
  input logic       phase_p2,
  input logic       fetch_stb,
  input logic       opcode_latch,
  input logic       pc_inc_en,
  input logic       xdata_cycle,
  input logic       insn_end
);
  localparam logic [2:0] LAST_NUM = 3'(N_STATES);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (state_num == 3'd1) && !phase_p2);

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> phase_p2 != $past(phase_p2));

  // R2
  state_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase_p2 && state_num != LAST_NUM) |=> state_num == $past(state_num) + 3'd1);

  // R3
  latch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opcode_latch |-> fetch_stb && (state_num == 3'd1) && !phase_p2);

  // R3
  latch_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opcode_latch |=> busy && phase_p2);

  // R4
  fetch_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> !phase_p2);

  // R5
  inc_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc_en |-> fetch_stb);

  // R6
  xdata_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xdata_cycle |-> !fetch_stb && !pc_inc_en);

  // R7
  end_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_end |-> (state_num == LAST_NUM) && phase_p2);

  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_end |=> !busy && (state_num == 3'd1) && !phase_p2);
endmodule

bind mc_state_seq mc_state_seq_chk #(.N_STATES(N_STATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .busy(busy),
  .state_num(state_num), .phase_p2(phase_p2), .fetch_stb(fetch_stb),
  .opcode_latch(opcode_latch), .pc_inc_en(pc_inc_en),
  .xdata_cycle(xdata_cycle), .insn_end(insn_end)
);

// File: tb/mc_state_seq_tb.sv
`timescale 1ns/1ps
module mc_state_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       insn_start = 1'b0;
  logic [2:0] insn_class = 3'd0;
  logic [2:0] state_num;
  logic       phase_p2, fetch_stb, opcode_latch, pc_inc_en, xdata_cycle, insn_end;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mc_state_seq u_dut (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_class(insn_class),
    .state_num(state_num), .phase_p2(phase_p2), .fetch_stb(fetch_stb),
    .opcode_latch(opcode_latch), .pc_inc_en(pc_inc_en),
    .xdata_cycle(xdata_cycle), .insn_end(insn_end)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // idle periods: start low, expect boundary state with all strobes quiet (R1)
  task automatic idle_hold(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      insn_start = 1'b0;
      #1;
      chk(state_num == 3'd1, "R1", "idle state_num", state_num, 1);
      chk(!phase_p2, "R1", "idle phase", phase_p2, 0);
      chk({fetch_stb, opcode_latch, pc_inc_en, xdata_cycle, insn_end} == 5'b0,
          "R1", "idle strobes", {fetch_stb, opcode_latch, pc_inc_en, xdata_cycle, insn_end}, 0);
    end
  endtask

  // one instruction, every period compared with a schedule built from the period count
  task automatic run_insn(input logic [2:0] cls, input string tag_latch);
    logic two_byte = (cls == 3'd1) || (cls == 3'd3);
    logic xmove    = (cls == 3'd4);
    int   ncyc     = ((cls == 3'd2) || (cls == 3'd3) || (cls == 3'd4)) ? 2 : 1;
    logic [2:0] junk = xmove ? 3'd1 : 3'd4;
    for (int k = 0; k < 12 * ncyc; k++) begin
      int   cyc = k / 12;
      int   s   = (k % 12) / 2;
      int   p   = k % 2;
      logic e_fetch = (p == 0) && (s == 0 || s == 3) && !(xmove && cyc == 1);
      logic e_inc   = (k == 0) || (cyc == 0 && s == 3 && p == 0 && two_byte);
      @(negedge clk);
      insn_start = (k == 0);
      insn_class = (k == 0) ? cls : junk;   // R3: later class changes must be ignored
      #1;
      chk(state_num == 3'(s + 1), "R2", "state_num", state_num, s + 1);
      chk(phase_p2 == p[0], "R2", "phase", phase_p2, p);
      chk(opcode_latch == (k == 0), tag_latch, "opcode_latch", opcode_latch, k == 0);
      chk(fetch_stb == e_fetch, xmove ? "R6" : "R4", "fetch_stb", fetch_stb, e_fetch);
      chk(pc_inc_en == e_inc, "R5", "pc_inc_en", pc_inc_en, e_inc);
      chk(xdata_cycle == (xmove && cyc == 1), "R6", "xdata_cycle", xdata_cycle, xmove && cyc == 1);
      chk(insn_end == (k == 12 * ncyc - 1), "R7", "insn_end", insn_end, k == 12 * ncyc - 1);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    #1;
    chk(state_num == 3'd1 && !phase_p2, "R1", "reset state", state_num, 1);
    chk({fetch_stb, pc_inc_en, xdata_cycle, insn_end} == 4'b0, "R1", "reset strobes",
        {fetch_stb, pc_inc_en, xdata_cycle, insn_end}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_hold(5);
    // R3 R4 R5 R7 per class, with idle gaps between them
    for (int c = 0; c < 8; c++) begin
      run_insn(3'(c), "R3");
      idle_hold(2);
    end
    // R8: back-to-back instructions with no gap
    run_insn(3'd4, "R3");
    run_insn(3'd1, "R8");
    run_insn(3'd3, "R8");
    run_insn(3'd0, "R8");
    idle_hold(3);
    // R1: reset mid-instruction returns to the boundary
    @(negedge clk);
    insn_start = 1'b1;
    insn_class = 3'd2;
    repeat (7) @(negedge clk);
    insn_start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle_hold(3);
    run_insn(3'd2, "R3");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule